// File: doc/BRIEF.md
# Wakeup Pin Event Detector

This block watches eight external wakeup inputs and raises a wakeup request when one of them shows an event. Each input has a separate enable bit and a polarity bit. The polarity bit selects whether a rising edge or a falling edge counts as the event. Every input first passes through a two-flop synchronizer. An event sets a sticky flag for that pin. The request output is the OR of all the flags, so power-control logic sees one level that stays high until software has cleared every flag that was set.

Enabling a pin whose synchronized level is already at the active level counts as an event. This covers the case where the pin was asserted before it was enabled. Flags can be cleared in only two ways: by reset, or by writing ones to a separate clear register, which always reads back as zero.

A simple synchronous register port holds the configuration. Writes take effect on the clock edge, and read data is driven combinationally from the address. The register file also stores a two-bit pull setting for each pin and a set of security bits. These are only held and exported to the pad and protection logic.

Top module: `wkp_detector`

## Requirements
- R1: After synchronous reset, every register and flag is zero: `wake_req` is 0, `pull_cfg`, `pin_secure` and `retain_secure` are 0, and all four addresses read 0.
- R2: Address 0 is the configuration register and reads back exactly what was written. Bits 7:0 enable pins 0..7. Bits 15:8 are the polarity of pins 0..7. Bits 31:16 hold a two-bit pull field per pin, with pin n at bits 16+2n+1:16+2n. The `pull_cfg` output equals bits 31:16.
- R3: A pin with polarity 0 that is enabled and sees a low-to-high change sets its flag. The flag is readable, and `wake_req` is high, after the third rising clock edge that follows the input change.
- R4: A pin with polarity 1 that is enabled and sees a high-to-low change sets its flag with the same three-edge latency.
- R5: Writing its enable bit to 1 while the pin's synchronized level is already active (high for polarity 0, low for polarity 1) sets its flag one edge after the write edge.
- R6: A disabled pin never sets its flag, whatever its input does. Disabling a pin leaves a flag that is already set unchanged.
- R7: Address 1 is the status register, with the flag of pin n in bit n and zeros above bit 7. Writes to it have no effect.
- R8: Address 2 is the clear register. Writing 1 to bit n clears flag n, and bits written as 0 leave their flags alone. Reads of address 2 return 0.
- R9: If an event and a clear write hit the same flag in the same cycle, the flag stays set.
- R10: Address 3 is the security register. Bits 7:0 hold one protection bit per pin and drive `pin_secure`. Bit 11 holds the retention protection bit and drives `retain_secure`. All other bits read as 0.
- R11: `wake_req` is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pin | input | 8 | Asynchronous wakeup inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| wake_req | output | 1 | OR of all wakeup flags |
| pull_cfg | output | 16 | Pull fields, two bits per pin |
| pin_secure | output | 8 | Per-pin protection bits |
| retain_secure | output | 1 | Retention protection bit |

## Verification
A change on an input reaches its flag after three rising edges: two synchronizer flops, then the flag register. The edge comparison uses the second flop and its delayed copy. An enable-arm event sets the flag one edge after the write edge. A clear takes effect on the write edge itself. The bench drives inputs on falling edges and holds each input pattern for at least five cycles before it reads status. Where the exact cycle matters (R3, R5, R9), it counts edges from the stimulus and samples half a cycle after the edge on which the result is due.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
    localparam int PINS     = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int PULL_W   = 2;
    localparam int PULL_LSB = 16;
    localparam int POL_LSB  = PINS;
    localparam int RSEC_BIT = 11;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG  = 2'd0,
        A_STAT = 2'd1,
        A_CLR  = 2'd2,
        A_SEC  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PINS*PULL_W-1:0] pull;
        logic [PINS-1:0]        pol;
        logic [PINS-1:0]        en;
    } cfg_t;

    typedef struct packed {
        logic            ret;
        logic [PINS-1:0] pin;
    } sec_t;

    function automatic logic [DATA_W-1:0] sec_to_word(sec_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PINS-1:0] = s.pin;
        w[RSEC_BIT] = s.ret;
        return w;
    endfunction
endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic st1, st2;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1 <= 1'b0;
                st2 <= 1'b0;
            end else begin
                st1 <= d_async[i];
                st2 <= st1;
            end
        end
        assign d_sync[i] = st2;
    end
endmodule

// File: rtl/wkp_edge.sv
module wkp_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] en,
    input  logic [W-1:0] pol,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic lvl_d, en_d;
        logic act_now, act_prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_d <= 1'b0;
                en_d  <= 1'b0;
            end else begin
                lvl_d <= lvl[i];
                en_d  <= en[i];
            end
        end
        // polarity 1 makes low the active level
        assign act_now  = lvl[i] ^ pol[i];
        assign act_prev = lvl_d ^ pol[i];
        // edge into active level, or enabling while already active
        assign evt[i] = en[i] & act_now & (~act_prev | ~en_d);
    end
endmodule

// File: rtl/wkp_regs.sv
module wkp_regs
    import wkp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PINS-1:0]   evt,
    output cfg_t              cfg,
    output sec_t              sec,
    output logic [PINS-1:0]   flags,
    output logic [DATA_W-1:0] rdata
);
    logic [PINS-1:0] clr_mask;

    assign clr_mask = (we && addr == A_CLR) ? wdata[PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            sec   <= '0;
            flags <= '0;
        end else begin
            if (we && addr == A_CFG) cfg <= cfg_t'(wdata);
            if (we && addr == A_SEC) begin
                sec.pin <= wdata[PINS-1:0];
                sec.ret <= wdata[RSEC_BIT];
            end
            // a set in the same cycle overrides the clear
            flags <= (flags & ~clr_mask) | evt;
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_CFG:  rdata = DATA_W'(cfg);
            A_STAT: rdata[PINS-1:0] = flags;
            A_SEC:  rdata = sec_to_word(sec);
            default: rdata = '0;
        endcase
    end

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == '0));
    a_r6_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((flags & ~$past(flags)) & ~$past(cfg.en)) == '0));
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt) & ~flags) == '0));
endmodule

// File: rtl/wkp_detector.sv
module wkp_detector
    import wkp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PINS-1:0]        wake_pin,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic                   wake_req,
    output logic [PINS*PULL_W-1:0] pull_cfg,
    output logic [PINS-1:0]        pin_secure,
    output logic                   retain_secure
);
    logic [PINS-1:0] lvl_s, evt, flags;
    cfg_t cfg;
    sec_t sec;

    wkp_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst(rst), .d_async(wake_pin), .d_sync(lvl_s)
    );

    wkp_edge #(.W(PINS)) u_edge (
        .clk(clk), .rst(rst), .lvl(lvl_s), .en(cfg.en), .pol(cfg.pol), .evt(evt)
    );

    wkp_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .evt(evt), .cfg(cfg), .sec(sec), .flags(flags), .rdata(reg_rdata)
    );

    assign wake_req      = |flags;
    assign pull_cfg      = cfg.pull;
    assign pin_secure    = sec.pin;
    assign retain_secure = sec.ret;

    a_r8_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_CLR) |-> (reg_rdata == '0));
    a_r11_req_follows: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (reg_addr != A_STAT || reg_rdata[PINS-1:0] != '0));
endmodule

// File: tb/sim_wkp_detector.sv
module sim_wkp_detector;
    localparam int P = 8;
    logic clk = 1'b0, rst = 1'b1;
    logic [P-1:0] wake_pin = '0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic wake_req, retain_secure;
    logic [15:0] pull_cfg;
    logic [P-1:0] pin_secure;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wkp_detector u0 (
        .clk(clk), .rst(rst), .wake_pin(wake_pin), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_req(wake_req), .pull_cfg(pull_cfg), .pin_secure(pin_secure),
        .retain_secure(retain_secure)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // expected flag set from one stable-to-stable change of the inputs
    function automatic logic [P-1:0] new_events(logic [P-1:0] en, logic [P-1:0] pol,
                                                logic [P-1:0] oldv, logic [P-1:0] newv);
        return en & ~(oldv ^ pol) & (newv ^ pol);
    endfunction

    initial begin
        logic [31:0] d;
        logic [P-1:0] exp_f, en, pol, oldv, newv;
        void'($urandom(32'd1234));
        idle(3);
        rst = 1'b0;
        // R1
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1", d, 0);
        end
        chk("R1", {wake_req, pull_cfg, pin_secure, retain_secure}, 0);

        // R2 configuration readback and pull export, all disabled
        wr(2'd0, 32'hA5C3_FF00);
        rd(2'd0, d);
        chk("R2", d, 32'hA5C3_FF00);
        chk("R2", pull_cfg, 16'hA5C3);
        // R10 security
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d);
        chk("R10", d, 32'h0000_08FF);
        chk("R10", {retain_secure, pin_secure}, 9'h1FF);
        wr(2'd3, 32'h0000_0805);
        chk("R10", {retain_secure, pin_secure}, 9'h105);

        // R6 disabled pins: toggle everything, no flag
        wr(2'd0, 32'h0);
        wake_pin = 8'hFF; idle(5);
        wake_pin = 8'h00; idle(5);
        rd(2'd1, d);
        chk("R6", d, 0);
        chk("R11", wake_req, 0);

        // R3 rising edge latency on pin 2
        wr(2'd0, 32'h0000_0004);
        @(negedge clk); wake_pin = 8'h04;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(2'd1, d);
        chk("R3", d, 0);
        @(negedge clk);
        rd(2'd1, d);
        chk("R3", d, 32'h4);
        chk("R11", wake_req, 1);
        // R7 status write ignored
        wr(2'd1, 32'h0);
        rd(2'd1, d);
        chk("R7", d, 32'h4);
        // R6 disabling keeps flag
        wr(2'd0, 32'h0);
        rd(2'd1, d);
        chk("R6", d, 32'h4);
        // R8 clear, zeros ignored
        wr(2'd2, 32'h0000_00FB);
        rd(2'd1, d);
        chk("R8", d, 32'h4);
        wr(2'd2, 32'h0000_0004);
        rd(2'd1, d);
        chk("R8", d, 0);
        chk("R11", wake_req, 0);

        // R4 falling edge pin 5
        wake_pin = 8'h20; idle(5);
        wr(2'd0, 32'h0000_2020);
        idle(2);
        rd(2'd1, d);
        chk("R4", d, 0);
        wake_pin = 8'h00; idle(5);
        rd(2'd1, d);
        chk("R4", d, 32'h20);
        wr(2'd2, 32'hFF);

        // R5 enable while active: pin 1 high rising, pin 6 low falling
        wr(2'd0, 32'h0000_4000);
        wake_pin = 8'h02; idle(5);
        rd(2'd1, d);
        chk("R5", d, 0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_4042;
        @(negedge clk);
        reg_we = 1'b0;
        rd(2'd1, d);
        chk("R5", d, 0);
        @(negedge clk);
        rd(2'd1, d);
        chk("R5", d, 32'h42);
        wr(2'd2, 32'hFF);

        // R9 same-cycle set and clear on pin 0
        wr(2'd0, 32'h0000_0001);
        wake_pin = 8'h01; idle(5);
        wake_pin = 8'h00; idle(5);
        rd(2'd1, d);
        chk("R9", d, 32'h1);
        @(negedge clk); wake_pin = 8'h01;
        @(negedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(2'd1, d);
        chk("R9", d, 32'h1);
        rd(2'd2, d);
        chk("R8", d, 0);
        wr(2'd2, 32'hFF);

        // random phase R3 R4 R6 R11
        oldv = wake_pin;
        for (int it = 0; it < 60; it++) begin
            en = 8'($urandom); pol = 8'($urandom);
            wake_pin = oldv;
            wr(2'd0, {16'($urandom), pol, 8'h00});
            wr(2'd2, 32'hFF);
            idle(4);
            wr(2'd0, {16'h0, pol, en});
            idle(2);
            wr(2'd2, 32'hFF);
            exp_f = '0;
            for (int k = 0; k < 3; k++) begin
                newv = 8'($urandom);
                wake_pin = newv;
                idle(5);
                exp_f |= new_events(en, pol, oldv, newv);
                oldv = newv;
            end
            rd(2'd1, d);
            chk("R3/R4 random", d, {24'h0, exp_f});
            chk("R11 random", wake_req, |exp_f);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule